// File: doc/BRIEF.md
# Packed Pixel Unpacker with Palette Lookup

This block sits between a pixel buffer that delivers 16-bit words and the colour outputs of a raster display. Each word carries several pixels of `PIX_W` bits, packed with the first pixel in the least-significant field. The block asks the buffer for a new word whenever the display is active and the horizontal counter reaches a word boundary. It catches the returned word in a shift register and moves one pixel into the lowest field on each clock. That field indexes a small palette, and the palette's colour goes into a registered RGB output.

The palette holds `2^PIX_W` entries of three colour components, each `RGB_BITS` wide. A plain write port loads it, and reset does not clear it. The path from the request to the coloured pixel on the outputs is a fixed three clocks (`PXU_PIPE_LAT`). A sync generator that drives this block starts its active region that many clocks early. The outputs go dark whenever the blanking input, delayed to line up with the pixel it belongs to, is set.

A three-state sequencer controls the datapath. `SQ_IDLE` holds the shift register while the display is blanked and no word is pending. `SQ_FETCH` marks the clock in which a requested word arrives and is loaded. `SQ_STREAM` shifts one pixel per clock. The transitions are:
- Any state moves to `SQ_FETCH` on a request.
- `SQ_FETCH` moves to `SQ_STREAM` when no new request follows.
- `SQ_STREAM` falls back to `SQ_IDLE` when blanking is seen without a request, and otherwise stays in `SQ_STREAM`.

Top module: `pixel_unpack_cmap`

## Requirements
- R1: `rd_req_o` is high in exactly those clocks where `blank_i` is low and `hcount_i` modulo `16/PIX_W` is zero. For `PIX_W`=4 this means the low two counter bits are both zero.
- R2: A word on `rd_data_i` is taken in the clock right after the request. The pixel in bits `[PIX_W-1:0]` of that word drives the RGB outputs in the third clock after the request clock.
- R3: The remaining pixels of a word follow in ascending bit-field order, one per clock. Consecutive words join with no gap and no repeated pixel.
- R4: The RGB outputs carry the palette entry selected by the pixel value. Entry bits are `{red, green, blue}` from most to least significant, each `RGB_BITS` wide.
- R5: When `blank_i` is high in a clock, all three colour outputs are zero three clocks later.
- R6: While reset is held, and in the first clock after it is released, all colour outputs are zero.
- R7: Palette entries written before a reset keep their values after it.
- R8: A palette write with `pal_we_i` high in a clock is used by every lookup from the next clock onward, including while pixels stream.
- R9: `rd_data_i` is ignored in every clock that does not directly follow a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blank_i | input | 1 | High while the display is outside its active area |
| hcount_i | input | CNT_W | Horizontal pixel counter |
| rd_req_o | output | 1 | Request for the next packed word from the buffer |
| rd_data_i | input | 16 | Packed word, valid in the clock after a request |
| pal_we_i | input | 1 | Palette write enable |
| pal_addr_i | input | PIX_W | Palette entry being written |
| pal_data_i | input | 3*RGB_BITS | Palette colour {red, green, blue} |
| red_o | output | RGB_BITS | Red component |
| green_o | output | RGB_BITS | Green component |
| blue_o | output | RGB_BITS | Blue component |

## Verification
The assertions check four things on every clock: no request is made while blanked, a load follows each request and only a request, the outputs are dark three clocks after any blanked clock, and the outputs are dark right after reset. Only the bench scenarios can show that pixels come out in the right order and colour across word joins. They also show that palette contents survive a reset, that a palette write made mid-stream takes effect at the correct pixel, and that the junk words offered between requests never reach the screen.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam int PXU_WORD_W   = 16;
    localparam int PXU_PIPE_LAT = 3;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_FETCH  = 2'd1,
        SQ_STREAM = 2'd2
    } seq_state_e;

endpackage

// File: rtl/pxu_req_seq.sv
module pxu_req_seq
    import pxu_pkg::*;
#(
    parameter int PIX_W = 4,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank_i,
    input  logic [CNT_W-1:0] hcount_i,
    output logic             rd_req_o,
    output logic             load_o,
    output logic             shift_o
);

    localparam int PIX_PER_WORD = PXU_WORD_W / PIX_W;
    localparam logic [CNT_W-1:0] SLOT_MASK = CNT_W'(PIX_PER_WORD - 1);

    seq_state_e state_q, state_d;
    logic       word_edge;

    assign word_edge = (hcount_i & SLOT_MASK) == '0;
    assign rd_req_o  = !blank_i && word_edge;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (rd_req_o) state_d = SQ_FETCH;
            end
            SQ_FETCH: begin
                if (rd_req_o) state_d = SQ_FETCH;
                else          state_d = SQ_STREAM;
            end
            SQ_STREAM: begin
                if (rd_req_o)     state_d = SQ_FETCH;
                else if (blank_i) state_d = SQ_IDLE;
                else              state_d = SQ_STREAM;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        load_o  = 1'b0;
        shift_o = 1'b0;
        unique case (state_q)
            SQ_IDLE:   ;
            SQ_FETCH:  load_o  = 1'b1;
            SQ_STREAM: shift_o = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/pxu_shifter.sv
module pxu_shifter
    import pxu_pkg::*;
#(
    parameter int PIX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic                  shift_i,
    input  logic [PXU_WORD_W-1:0] word_i,
    output logic [PIX_W-1:0]      pix_o
);

    logic [PXU_WORD_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (load_i)  sr_q <= word_i;
        else if (shift_i) sr_q <= sr_q >> PIX_W;
    end

    assign pix_o = sr_q[PIX_W-1:0];

endmodule

// File: rtl/pxu_palette.sv
module pxu_palette #(
    parameter int PIX_W    = 4,
    parameter int RGB_BITS = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [PIX_W-1:0]      waddr_i,
    input  logic [3*RGB_BITS-1:0] wdata_i,
    input  logic [PIX_W-1:0]      idx_i,
    input  logic                  dark_i,
    output logic [3*RGB_BITS-1:0] rgb_o
);

    localparam int PAL_N = 1 << PIX_W;
    localparam int COL_W = 3 * RGB_BITS;

    logic [COL_W-1:0] entry_q [PAL_N];
    logic [COL_W-1:0] rgb_q;

    always_ff @(posedge clk) begin
        if (we_i) entry_q[waddr_i] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rgb_q <= '0;
        else if (dark_i) rgb_q <= '0;
        else             rgb_q <= entry_q[idx_i];
    end

    assign rgb_o = rgb_q;

endmodule

// File: rtl/pixel_unpack_cmap.sv
module pixel_unpack_cmap
    import pxu_pkg::*;
#(
    parameter int PIX_W    = 4,
    parameter int RGB_BITS = 1,
    parameter int CNT_W    = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  blank_i,
    input  logic [CNT_W-1:0]      hcount_i,
    output logic                  rd_req_o,
    input  logic [PXU_WORD_W-1:0] rd_data_i,
    input  logic                  pal_we_i,
    input  logic [PIX_W-1:0]      pal_addr_i,
    input  logic [3*RGB_BITS-1:0] pal_data_i,
    output logic [RGB_BITS-1:0]   red_o,
    output logic [RGB_BITS-1:0]   green_o,
    output logic [RGB_BITS-1:0]   blue_o
);

    localparam int COL_W        = 3 * RGB_BITS;
    localparam int BLANK_STAGES = PXU_PIPE_LAT - 1;

    logic             load_w;
    logic             shift_w;
    logic [PIX_W-1:0] pix_w;
    logic [COL_W-1:0] rgb_w;
    logic             blank_pipe [BLANK_STAGES+1];

    pxu_req_seq #(.PIX_W(PIX_W), .CNT_W(CNT_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .blank_i  (blank_i),
        .hcount_i (hcount_i),
        .rd_req_o (rd_req_o),
        .load_o   (load_w),
        .shift_o  (shift_w)
    );

    pxu_shifter #(.PIX_W(PIX_W)) shf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .shift_i (shift_w),
        .word_i  (rd_data_i),
        .pix_o   (pix_w)
    );

    assign blank_pipe[0] = blank_i;

    for (genvar gi = 1; gi <= BLANK_STAGES; gi++) begin : g_blank_dly
        always_ff @(posedge clk) begin
            if (!rst_n) blank_pipe[gi] <= 1'b1;
            else        blank_pipe[gi] <= blank_pipe[gi-1];
        end
    end

    pxu_palette #(.PIX_W(PIX_W), .RGB_BITS(RGB_BITS)) pal_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (pal_we_i),
        .waddr_i (pal_addr_i),
        .wdata_i (pal_data_i),
        .idx_i   (pix_w),
        .dark_i  (blank_pipe[BLANK_STAGES]),
        .rgb_o   (rgb_w)
    );

    assign red_o   = rgb_w[COL_W-1 -: RGB_BITS];
    assign green_o = rgb_w[2*RGB_BITS-1 -: RGB_BITS];
    assign blue_o  = rgb_w[RGB_BITS-1:0];

endmodule

// File: rtl/pxu_checker.sv
module pxu_checker #(
    parameter int COL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             blank_i,
    input logic             rd_req_o,
    input logic             load,
    input logic [COL_W-1:0] rgb
);

    AST_NO_REQ_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |-> !rd_req_o); // R1

    AST_LOAD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> load); // R2

    AST_NO_STRAY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_o |=> !load); // R9

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(blank_i, 2) |=> (rgb == '0)); // R5

    AST_RESET_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rgb == '0)); // R6

endmodule

bind pixel_unpack_cmap pxu_checker #(.COL_W(3 * RGB_BITS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .blank_i  (blank_i),
    .rd_req_o (rd_req_o),
    .load     (load_w),
    .rgb      ({red_o, green_o, blue_o})
);

// File: tb/pixel_unpack_cmap_tb_top.sv
module pixel_unpack_cmap_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PIX_W      = 4;
    localparam int RGB_BITS   = 1;
    localparam int CNT_W      = 10;
    localparam int PPW        = 16 / PIX_W;
    localparam int PAL_N      = 1 << PIX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             blank_i = 1'b1;
    logic [CNT_W-1:0] hcount_i = '0;
    logic             rd_req_o;
    logic [15:0]      rd_data_i = '0;
    logic             pal_we_i = 1'b0;
    logic [PIX_W-1:0] pal_addr_i = '0;
    logic [2:0]       pal_data_i = '0;
    logic             red_o, green_o, blue_o;

    int checks = 0;
    int fails  = 0;

    logic [2:0]  pal_m [PAL_N];
    bit          p_blank [3];
    int          p_idx [3];
    logic [15:0] cur_word;
    logic [15:0] next_data;
    bit          prev_req;
    int          wseed;
    bit          pw_en;
    int          pw_addr;
    logic [2:0]  pw_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixel_unpack_cmap #(.PIX_W(PIX_W), .RGB_BITS(RGB_BITS), .CNT_W(CNT_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .blank_i    (blank_i),
        .hcount_i   (hcount_i),
        .rd_req_o   (rd_req_o),
        .rd_data_i  (rd_data_i),
        .pal_we_i   (pal_we_i),
        .pal_addr_i (pal_addr_i),
        .pal_data_i (pal_data_i),
        .red_o      (red_o),
        .green_o    (green_o),
        .blue_o     (blue_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 3; i++) begin
            p_blank[i] = 1'b1;
            p_idx[i]   = 0;
        end
        prev_req = 1'b0;
        pw_en    = 1'b0;
    endtask

    // one pixel clock: compare the output of three clocks ago, then drive
    task automatic step(input bit blank, input int h, input bit we,
                        input int waddr, input logic [2:0] wdata, input string tag);
        logic [2:0] exp;
        bit         req;
        int         idx;
        @(negedge clk);
        exp = p_blank[2] ? 3'b000 : pal_m[p_idx[2]];
        check(tag, {13'd0, red_o, green_o, blue_o}, {13'd0, exp});
        if (pw_en) pal_m[pw_addr] = pw_data;
        rd_data_i  = prev_req ? next_data : (16'hA5C3 ^ 16'(h * 4099));  // junk otherwise, R9
        blank_i    = blank;
        hcount_i   = CNT_W'(h);
        pal_we_i   = we;
        pal_addr_i = PIX_W'(waddr);
        pal_data_i = wdata;
        req = !blank && (h % PPW == 0);
        #1;
        check("R1 request rule", {15'd0, rd_req_o}, {15'd0, req});
        if (req) begin
            wseed     = wseed * 1103 + 12345;
            next_data = 16'(wseed ^ (wseed >> 7));
            cur_word  = next_data;
        end
        idx = int'((cur_word >> (PIX_W * (h % PPW))) & 16'(PAL_N - 1));
        p_blank[2] = p_blank[1]; p_idx[2] = p_idx[1];
        p_blank[1] = p_blank[0]; p_idx[1] = p_idx[0];
        p_blank[0] = blank;      p_idx[0] = idx;
        prev_req = req;
        pw_en    = we;
        pw_addr  = waddr;
        pw_data  = wdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        blank_i  = 1'b1;
        pal_we_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R6 dark in reset", {13'd0, red_o, green_o, blue_o}, 16'd0);
        end
        rst_n = 1'b1;
        model_clear();
    endtask

    task automatic run_line(input int active, input int total, input string tag);
        for (int h = 0; h < total; h++) step(h >= active, h, 1'b0, 0, 3'b000, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks + 0);
        $finish;
    end

    initial begin
        wseed    = 7;
        cur_word = '0;
        model_clear();
        do_reset();
        // palette load while blanked, R8
        for (int i = 0; i < PAL_N; i++) step(1'b1, 40 + i, 1'b1, i, 3'((i * 5 + 3) & 7), "R8 palette load");
        // R2 latency on first line, then streaming order and colours
        run_line(32, 40, "R2 first pixel latency");
        for (int l = 0; l < 3; l++) run_line(32, 40, "R3 R4 R9 stream");
        // active area ends mid-word, then a fully blanked line
        run_line(30, 40, "R5 partial word blanked");
        run_line(0, 40, "R5 blank line");
        // palette rewrite during active pixels
        for (int h = 0; h < 40; h++)
            step(h >= 32, h, (h % 3) == 1, (h * 7) % PAL_N, 3'((h * 3 + 1) & 7), "R8 write mid stream");
        run_line(32, 40, "R4 after rewrite");
        // reset mid line; palette must survive
        for (int h = 0; h < 13; h++) step(1'b0, h, 1'b0, 0, 3'b000, "R3 before reset");
        do_reset();
        step(1'b1, 39, 1'b0, 0, 3'b000, "R6 first clock after reset");
        run_line(32, 40, "R7 palette kept");
        run_line(32, 40, "R7 palette kept");
        for (int i = 0; i < 4; i++) step(1'b1, 32 + i, 1'b0, 0, 3'b000, "R5 drain");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule